// File: doc/BRIEF.md
# LFSR-Coded Saturating Rank Counter

This block is a small per-pixel counter that tallies how many neighbourhood comparators sit in the low state at the present ramp level. A neighbourhood scan presents one comparator bit at a time together with a count strobe. Each strobe that arrives while the presented bit is low moves the counter one position down. Once the counter reaches its terminal state it stops, so later strobes in the same ramp step have no effect. The terminal flag then tells the pixel that the requested rank has been reached.

To keep each pixel cheap, the count register is not a binary counter. It is a 5-bit Fibonacci shift register with XNOR feedback, and one decrement is one shift. A load strobe presets the register with a rank that has already been turned into shift-register code, normally at the start of every ramp step. That translation is done by a combinational encoder which walks the sequence backwards from the terminal state. The encoder is also brought out at the top of the block, so the shared rank bus can be encoded once and then fanned out to the pixels.

Top module: `rank_lfsr_counter`

## Requirements
- R1: While reset is asserted, and after it is released, the count state is 5'b00000 (the terminal state) until the first load.
- R2: One cycle after an edge at which load_i is high, count_state_o equals rank_word_i. A load wins over a count strobe in the same cycle.
- R3: With load_i low, step_i high, cmp_bit_i low and the state not terminal, the next state is {s[3:0], ~(s[4] ^ s[2])}, where s is the current state.
- R4: A count strobe while cmp_bit_i is high (the examined pixel is brighter than the ramp) leaves the state unchanged.
- R5: With step_i low and load_i low, the state is unchanged whatever cmp_bit_i is.
- R6: terminal_o is high exactly when the count state is 5'b00000, and it follows the state register with no extra cycle.
- R7: In the terminal state, count strobes with cmp_bit_i low are ignored; only a load moves the state.
- R8: For a binary rank r from 0 to 30 on rank_bin_i, rank_code_o is the state that reaches 5'b00000 after exactly r decrements and not earlier.
- R9: A binary rank of 31 is treated as 30; rank_code_o then equals the code for rank 30.
- R10: rank_code_o is never 5'b11111, the state in which the XNOR register locks up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| load_i | input | 1 | Preset strobe; loads rank_word_i |
| rank_word_i | input | WIDTH | Preset value, already in shift-register code |
| step_i | input | 1 | Count strobe for the neighbour presented now |
| cmp_bit_i | input | 1 | Comparator bit of that neighbour; low means darker than the ramp |
| rank_bin_i | input | WIDTH | Binary rank for the encoder |
| rank_code_o | output | WIDTH | Encoded preset for rank_bin_i (combinational) |
| count_state_o | output | WIDTH | Present count state |
| terminal_o | output | 1 | High when the count state is terminal |

## Verification
The encoder is combinational, so the bench reads rank_code_o one time step after it sets rank_bin_i, with no clock edge in between. Loads and count strobes act through a single register. The bench therefore drives them just after a rising edge and reads count_state_o and terminal_o just after the following rising edge. That puts every check exactly one cycle after its stimulus, which catches an early or late change of the flag. In the rank sweep, terminal_o is checked after every dark strobe, so a flag that rises one strobe too soon or too late is seen at the strobe where it happens.

// File: rtl/rank_lfsr_pkg.sv
package rank_lfsr_pkg;

   localparam int unsigned MIN_W = 3;
   localparam int unsigned MAX_W = 8;

   // Maximal-length feedback masks; bit (W-1) is always a tap.
   // Every mask has an even tap count, so the all-ones word is the XNOR lock-up state.
   function automatic logic [MAX_W-1:0] tap_mask(input int unsigned w);
      logic [MAX_W-1:0] m;
      case (w)
         3:       m = 8'b0000_0110;
         4:       m = 8'b0000_1100;
         5:       m = 8'b0001_0100;
         6:       m = 8'b0011_0000;
         7:       m = 8'b0110_0000;
         8:       m = 8'b1011_1000;
         default: m = 8'b0000_0000;
      endcase
      return m;
   endfunction

   function automatic int unsigned tap_count(input int unsigned w);
      logic [MAX_W-1:0] m;
      int unsigned n;
      m = tap_mask(w);
      n = 0;
      for (int i = 0; i < MAX_W; i++) n += m[i];
      return n;
   endfunction

endpackage

// File: rtl/rank_lfsr_step.sv
module rank_lfsr_step #(
   parameter int unsigned W        = 5,
   parameter bit          BACKWARD = 1'b0
) (
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o
);
   import rank_lfsr_pkg::*;

   localparam logic [MAX_W-1:0] MASK_FULL = tap_mask(W);
   localparam logic [W-1:0]     MASK      = MASK_FULL[W-1:0];
   localparam int unsigned      TAPS      = tap_count(W);

   generate
      if (W < MIN_W || W > MAX_W) begin : g_bad_width
         $fatal(1, "rank_lfsr_step: width out of supported range");
      end
      if (TAPS % 2 != 0) begin : g_bad_taps
         $fatal(1, "rank_lfsr_step: tap count must be even");
      end

      if (!BACKWARD) begin : g_fwd
         if (TAPS == 2) begin : g_two_tap
            localparam int unsigned LO = (MASK[W-2] ? W-2 :
                                          (MASK[W-3] ? W-3 : 0));
            always_comb nxt_o = {cur_i[W-2:0], ~(cur_i[W-1] ^ cur_i[LO])};
         end else begin : g_multi_tap
            always_comb nxt_o = {cur_i[W-2:0], ~(^(cur_i & MASK))};
         end
      end else begin : g_bwd
         // Recover the bit that was shifted out at the top.
         always_comb
            nxt_o = {~cur_i[0] ^ (^(cur_i[W-1:1] & MASK[W-2:0])), cur_i[W-1:1]};
      end
   endgenerate

endmodule

// File: rtl/rank_lfsr_encoder.sv
module rank_lfsr_encoder #(
   parameter int unsigned W        = 5,
   parameter logic [W-1:0] TERMINAL = '0
) (
   input  logic [W-1:0] rank_i,
   output logic [W-1:0] code_o
);
   localparam int unsigned MAX_RANK = (1 << W) - 2;

   logic [W-1:0] chain [0:MAX_RANK];
   logic [W-1:0] rank_sat;

   assign chain[0] = TERMINAL;

   generate
      for (genvar k = 1; k <= MAX_RANK; k++) begin : g_back
         rank_lfsr_step #(.W(W), .BACKWARD(1'b1)) u_back (
            .cur_i (chain[k-1]),
            .nxt_o (chain[k])
         );
      end
   endgenerate

   always_comb begin
      if (rank_i > W'(MAX_RANK)) rank_sat = W'(MAX_RANK);
      else                       rank_sat = rank_i;
   end

   assign code_o = chain[rank_sat];

   // R10: the lock-up word must never be handed to a counter
   always_comb begin
      a_r10_no_lockup: assert (!(code_o === {W{1'b1}}));
   end

endmodule

// File: rtl/rank_lfsr_core.sv
module rank_lfsr_core #(
   parameter int unsigned W        = 5,
   parameter logic [W-1:0] TERMINAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] word_i,
   input  logic         step_i,
   input  logic         dark_i,
   output logic [W-1:0] state_o,
   output logic         term_o
);
   logic [W-1:0] state_q;
   logic [W-1:0] state_nx;
   logic         term;
   logic         advance;

   rank_lfsr_step #(.W(W), .BACKWARD(1'b0)) u_fwd (
      .cur_i (state_q),
      .nxt_o (state_nx)
   );

   assign term    = (state_q == TERMINAL);
   assign advance = step_i & dark_i & ~term;

   always_ff @(posedge clk) begin
      if (!rst_n)      state_q <= TERMINAL;
      else if (load_i) state_q <= word_i;
      else if (advance) state_q <= state_nx;
   end

   assign state_o = state_q;
   assign term_o  = term;

   a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (state_o == $past(word_i)));

   a_r4_bright_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !dark_i && !load_i) |=> $stable(state_o));

   a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(state_o));

   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (term_o && !load_i) |=> (state_o == TERMINAL));

   a_r3_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && dark_i && !load_i && !term_o && state_o != {W{1'b1}})
         |=> (state_o != $past(state_o)));

endmodule

// File: rtl/rank_lfsr_counter.sv
module rank_lfsr_counter #(
   parameter int unsigned WIDTH    = 5,
   parameter logic [WIDTH-1:0] TERMINAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] rank_word_i,
   input  logic             step_i,
   input  logic             cmp_bit_i,
   input  logic [WIDTH-1:0] rank_bin_i,
   output logic [WIDTH-1:0] rank_code_o,
   output logic [WIDTH-1:0] count_state_o,
   output logic             terminal_o
);
   generate
      if (TERMINAL == {WIDTH{1'b1}}) begin : g_bad_terminal
         $fatal(1, "rank_lfsr_counter: terminal state cannot be the lock-up word");
      end
   endgenerate

   logic dark;
   assign dark = ~cmp_bit_i;

   rank_lfsr_encoder #(.W(WIDTH), .TERMINAL(TERMINAL)) u_enc (
      .rank_i (rank_bin_i),
      .code_o (rank_code_o)
   );

   rank_lfsr_core #(.W(WIDTH), .TERMINAL(TERMINAL)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .word_i  (rank_word_i),
      .step_i  (step_i),
      .dark_i  (dark),
      .state_o (count_state_o),
      .term_o  (terminal_o)
   );

   // R6: the flag and the state agree at the ports
   a_r6_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
      terminal_o |-> (count_state_o == TERMINAL));

endmodule

// File: tb/test_rank_lfsr_counter.sv
`timescale 1ns/1ps
module test_rank_lfsr_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic [4:0] rank_word_i = '0;
   logic       step_i = 1'b0;
   logic       cmp_bit_i = 1'b1;
   logic [4:0] rank_bin_i = '0;
   logic [4:0] rank_code_o;
   logic [4:0] count_state_o;
   logic       terminal_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   rank_lfsr_counter i_rank_lfsr_counter (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (load_i),
      .rank_word_i   (rank_word_i),
      .step_i        (step_i),
      .cmp_bit_i     (cmp_bit_i),
      .rank_bin_i    (rank_bin_i),
      .rank_code_o   (rank_code_o),
      .count_state_o (count_state_o),
      .terminal_o    (terminal_o)
   );

   function automatic logic [4:0] m_next(input logic [4:0] s);
      return {s[3:0], ~(s[4] ^ s[2])};
   endfunction

   // Forward search: the start state that first hits zero after r steps.
   function automatic logic [4:0] m_code(input int r);
      int rr;
      logic [4:0] x;
      bit ok;
      rr = (r > 30) ? 30 : r;
      for (int c = 0; c < 31; c++) begin
         x  = 5'(c);
         ok = 1'b1;
         for (int i = 0; i < rr; i++) begin
            if (x == 5'd0) ok = 1'b0;
            x = m_next(x);
         end
         if (ok && x == 5'd0) return 5'(c);
      end
      return 5'h1f;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_load(input logic [4:0] w);
      load_i = 1'b1; rank_word_i = w;
      tick();
      load_i = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      check(count_state_o == 5'd0, "R1 state in reset", count_state_o, 0);
      check(terminal_o == 1'b1, "R6 flag in reset", terminal_o, 1);
      rst_n = 1'b1;
      step_i = 1'b1; cmp_bit_i = 1'b0;
      tick();
      step_i = 1'b0; cmp_bit_i = 1'b1;
      check(count_state_o == 5'd0, "R1 state after reset", count_state_o, 0);
   endtask

   task automatic t_load();
      do_load(5'h0a);
      check(count_state_o == 5'h0a, "R2 load", count_state_o, 5'h0a);
      check(terminal_o == 1'b0, "R6 flag low", terminal_o, 0);
      load_i = 1'b1; rank_word_i = 5'h13; step_i = 1'b1; cmp_bit_i = 1'b0;
      tick();
      load_i = 1'b0; step_i = 1'b0; cmp_bit_i = 1'b1;
      check(count_state_o == 5'h13, "R2 load beats strobe", count_state_o, 5'h13);
   endtask

   task automatic t_hold();
      do_load(5'h0a);
      step_i = 1'b1; cmp_bit_i = 1'b1;
      repeat (3) tick();
      step_i = 1'b0;
      check(count_state_o == 5'h0a, "R4 bright strobe ignored", count_state_o, 5'h0a);
      cmp_bit_i = 1'b0;
      repeat (3) tick();
      cmp_bit_i = 1'b1;
      check(count_state_o == 5'h0a, "R5 no strobe no change", count_state_o, 5'h0a);
   endtask

   task automatic t_steps();
      logic [4:0] exp;
      do_load(5'h15);
      exp = 5'h15;
      for (int i = 0; i < 4; i++) begin
         step_i = 1'b1; cmp_bit_i = 1'b0;
         tick();
         exp = m_next(exp);
         check(count_state_o == exp, "R3 one decrement", count_state_o, exp);
      end
      step_i = 1'b0; cmp_bit_i = 1'b1;
   endtask

   task automatic t_sweep();
      logic [4:0] code;
      for (int r = 0; r <= 30; r++) begin
         rank_bin_i = 5'(r);
         #1;
         code = m_code(r);
         check(rank_code_o == code, "R8 encoder value", rank_code_o, code);
         check(rank_code_o != 5'h1f, "R10 no lock-up code", rank_code_o, 0);
         do_load(rank_code_o);
         check(terminal_o == (r == 0), "R6 flag after load", terminal_o, (r == 0));
         for (int i = 1; i <= r; i++) begin
            step_i = 1'b1; cmp_bit_i = 1'b1;   // bright neighbour, not counted
            tick();
            cmp_bit_i = 1'b0;                  // dark neighbour, counted
            tick();
            check(terminal_o == (i == r), "R8 flag on r-th dark strobe", terminal_o, (i == r));
         end
         step_i = 1'b1; cmp_bit_i = 1'b0;
         repeat (2) tick();
         step_i = 1'b0; cmp_bit_i = 1'b1;
         check(count_state_o == 5'd0, "R7 frozen at terminal", count_state_o, 0);
      end
   endtask

   task automatic t_clamp();
      logic [4:0] code;
      rank_bin_i = 5'd31;
      #1;
      code = m_code(30);
      check(rank_code_o == code, "R9 rank 31 clamps to 30", rank_code_o, code);
      check(rank_code_o != 5'h1f, "R10 no lock-up when clamped", rank_code_o, 0);
   endtask

   initial begin
      t_reset();
      t_load();
      t_hold();
      t_steps();
      t_sweep();
      t_clamp();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule